// File: doc/BRIEF.md
# Encoder run-mode sequencer

This block decides which run mode a stream encoder is in and drives the enables that follow from it. A host issues one-cycle command codes. The datapath reports each completed group of pictures and each completed audio frame as a one-cycle pulse. The sequencer answers with enables for input processing and for the multiplexer output, a busy flag, one-cycle strobes that ask the datapath to append an end-of-sequence marker or to save its buffer-model state, strobes that restore or reload the configuration, a clock-run enable for the power-down state, and an active-low completion interrupt.

Most commands take effect at the next clock edge. A stop or pause issued while encoding is deferred. The encoder keeps running until a picture-group boundary and an audio-frame boundary have both been seen after the command. It then settles in Stop, with an end marker, or in Paused, with the buffer-model state saved. A start issued from Idle spends one cycle in Stop before it reaches Encode. A forced reconfigure breaks out of a deferred wait, restores the defaults and then runs a timed reload of the saved settings. Configuration writes from the host are checked here against the current mode before they reach the register file.

Top module: `mode_ctl_top`

## Requirements
- R1: While hard reset is asserted and in the first cycle after it is released, mode is Idle, both enables and busy are low, irq_n and clk_run are high, and no strobe is active.
- R2: Enable (code 3) in Idle moves the block to Stop in one cycle. In Stop, in_proc_en is 1 and mux_out_en is 0.
- R3: Start (code 4) in Stop moves the block to Encode in one cycle, and in Encode both enables are 1. Start in Idle first gives one cycle of Stop with busy high and then Encode. Encode is never entered directly from Idle.
- R4: Stop (code 5) in Encode keeps the block in Encode with busy high. It completes once a gop_end pulse and an afr_end pulse have both arrived in cycles after the accept cycle, in either order or together. The block then enters Stop and eos_req is high for exactly that first cycle.
- R5: Pause (code 6) in Encode waits in the same way as R4, then enters Paused with save_state high for one cycle and eos_req low. In Paused, in_proc_en is 1 and mux_out_en is 0. Start from Paused returns to Encode in one cycle.
- R6: Soft reset (code 1) is accepted in Idle, Stop, Encode, Paused and during a deferred wait. It enters Idle in one cycle and pulses cfg_defaults for one cycle.
- R7: Reconfigure (code 2) in Stop or Paused enters Idle in one cycle without pulsing cfg_defaults.
- R8: Sleep (code 7) in Idle enters Power-down, where clk_run is 0. Every command is ignored there, and only hard reset leaves it.
- R9: A command that is not listed as legal in the current mode is dropped. During the Start pass through Stop and during a reload, every command is dropped. During a deferred wait, only soft reset and forced reconfigure are taken.
- R10: Forced reconfigure (code 8) is accepted in any mode except Power-down, including during a deferred wait. It pulses cfg_defaults for one cycle and holds cfg_reload and busy high for RELOAD_CYCLES cycles with both enables low. It then settles in Idle.
- R11: A configuration write is always accepted in Idle. In Stop, Encode and Paused, and during the Start pass or a deferred wait, only writes marked dynamic are accepted. During a reload or in Power-down, every write is rejected. cfg_wr_ok or cfg_wr_err answers in the same cycle, and never both.
- R12: Every completed transition sets an interrupt-pending bit. irq_n is low while that bit is set and irq_mask is 0. irq_clear clears the bit, but a completion in the same cycle wins. Accepting a deferred command raises nothing.
- R13: The mode output encodes Idle=0, Stop=1, Encode=2, Paused=3 and Power-down=4. Command codes 0 and 9 to 15 are ignored in every mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Hard reset, active low, asynchronous |
| cmd_valid | input | 1 | A command is presented this cycle |
| cmd_code | input | 4 | Command code (see R13) |
| gop_end | input | 1 | Pulse: a group of pictures has completed |
| afr_end | input | 1 | Pulse: an audio frame has completed |
| cfg_wr | input | 1 | Host configuration write this cycle |
| cfg_dyn | input | 1 | The write targets a dynamic parameter |
| irq_mask | input | 1 | 1 suppresses irq_n |
| irq_clear | input | 1 | Write-one-to-clear of the pending bit |
| mode | output | 3 | Current run mode |
| in_proc_en | output | 1 | Video and audio input processing enable |
| mux_out_en | output | 1 | Multiplexer stream output enable |
| eos_req | output | 1 | Append an end-of-sequence marker (pulse) |
| save_state | output | 1 | Save the buffer-model state (pulse) |
| cfg_defaults | output | 1 | Restore the default configuration (pulse) |
| cfg_reload | output | 1 | Saved settings are being reloaded |
| busy | output | 1 | Transition in progress |
| clk_run | output | 1 | Internal clock enable, 0 in Power-down |
| cfg_wr_ok | output | 1 | The current write is accepted |
| cfg_wr_err | output | 1 | The current write is rejected |
| irq_n | output | 1 | Completion interrupt, active low |

## Verification
Some properties are checked by the assertions on every cycle. Encode is never reached straight from Idle. The end-marker strobe appears only on the first cycle of Stop after Encode, and the save strobe never comes together with it. Power-down never ends without a hard reset. A reload keeps both enables low. A write is never both accepted and rejected. The pending interrupt bit holds until it is cleared.

Other behaviour needs the bench's scenarios. These cover which commands each mode accepts or drops, the boundary counting that excludes the accept cycle, the exact length of the reload, a soft reset cutting short a deferred wait, the mode-dependent write filter, and the interaction of mask, clear and completion on the interrupt.

// File: rtl/mc_pkg.sv
package mc_pkg;

  typedef enum logic [2:0] {
    S_IDLE, S_STOP, S_ENC, S_PAUSED, S_OFF, S_PASS, S_DRAIN, S_RELOAD
  } ctl_state_e;

  localparam logic [2:0] MODE_IDLE   = 3'd0;
  localparam logic [2:0] MODE_STOP   = 3'd1;
  localparam logic [2:0] MODE_ENCODE = 3'd2;
  localparam logic [2:0] MODE_PAUSED = 3'd3;
  localparam logic [2:0] MODE_OFF    = 3'd4;

  localparam logic [3:0] CMD_SRST   = 4'd1;
  localparam logic [3:0] CMD_RECONF = 4'd2;
  localparam logic [3:0] CMD_ENABLE = 4'd3;
  localparam logic [3:0] CMD_START  = 4'd4;
  localparam logic [3:0] CMD_HALT   = 4'd5;
  localparam logic [3:0] CMD_PAUSE  = 4'd6;
  localparam logic [3:0] CMD_SLEEP  = 4'd7;
  localparam logic [3:0] CMD_FORCE  = 4'd8;

  // Externally visible mode for each internal state.
  function automatic logic [2:0] mode_of(ctl_state_e s);
    case (s)
      S_STOP, S_PASS:  return MODE_STOP;
      S_ENC, S_DRAIN:  return MODE_ENCODE;
      S_PAUSED:        return MODE_PAUSED;
      S_OFF:           return MODE_OFF;
      default:         return MODE_IDLE;
    endcase
  endfunction

  // Which command codes a state accepts.
  function automatic logic cmd_ok(ctl_state_e s, logic [3:0] c);
    case (s)
      S_IDLE:   return c inside {CMD_SRST, CMD_ENABLE, CMD_START, CMD_SLEEP, CMD_FORCE};
      S_STOP:   return c inside {CMD_SRST, CMD_RECONF, CMD_START, CMD_FORCE};
      S_ENC:    return c inside {CMD_SRST, CMD_HALT, CMD_PAUSE, CMD_FORCE};
      S_PAUSED: return c inside {CMD_SRST, CMD_RECONF, CMD_START, CMD_FORCE};
      S_DRAIN:  return c inside {CMD_SRST, CMD_FORCE};
      default:  return 1'b0;
    endcase
  endfunction

  // Write filter: Idle takes everything, running modes only dynamic writes.
  function automatic logic cfg_allow(ctl_state_e s, logic dyn);
    case (s)
      S_IDLE:                                   return 1'b1;
      S_STOP, S_ENC, S_PAUSED, S_PASS, S_DRAIN: return dyn;
      default:                                  return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/mc_cmd_filter.sv
module mc_cmd_filter
  import mc_pkg::*;
(
  input  ctl_state_e st,
  input  logic       vld,
  input  logic [3:0] code,
  output logic       acc
);
  assign acc = vld && cmd_ok(st, code);
endmodule

// File: rtl/mc_boundary_track.sv
module mc_boundary_track #(
  parameter int N_SRC = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active,
  input  logic [N_SRC-1:0] evt,
  output logic             fin
);
  logic [N_SRC-1:0] got;

  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    logic hit_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        hit_q <= 1'b0;
      else if (!active)  hit_q <= 1'b0;
      else if (evt[i])   hit_q <= 1'b1;
    end
    assign got[i] = hit_q | evt[i];
  end

  assign fin = active && (&got);

  // R4: a boundary seen outside the wait never counts toward completion
  a_r4_no_stale_fin: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> !fin || ((evt & ~got) == '0 && (&evt)) || $past(active) == 1'b0 && (&evt));
endmodule

// File: rtl/mc_reload_timer.sv
module mc_reload_timer #(
  parameter int RELOAD_CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic active,
  output logic zero
);
  localparam int CW = (RELOAD_CYCLES > 1) ? $clog2(RELOAD_CYCLES) : 1;
  localparam logic [CW-1:0] LOAD = CW'(RELOAD_CYCLES - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       cnt_q <= '0;
    else if (start)                   cnt_q <= LOAD;
    else if (active && cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);

  a_r10_count_range: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LOAD);
  a_r10_count_steps: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !start && cnt_q != '0) |=> cnt_q == $past(cnt_q) - 1'b1);
endmodule

// File: rtl/mc_irq_unit.sv
module mc_irq_unit (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  input  logic mask,
  output logic irq_n
);
  logic pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    pend_q <= 1'b0;
    else if (set)  pend_q <= 1'b1;
    else if (clr)  pend_q <= 1'b0;
  end

  assign irq_n = ~(pend_q & ~mask);

  a_r12_pending_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !clr) |=> pend_q);
  a_r12_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    set |=> pend_q);
endmodule

// File: rtl/mode_ctl_top.sv
module mode_ctl_top
  import mc_pkg::*;
#(
  parameter int RELOAD_CYCLES = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  input  logic [3:0] cmd_code,
  input  logic       gop_end,
  input  logic       afr_end,
  input  logic       cfg_wr,
  input  logic       cfg_dyn,
  input  logic       irq_mask,
  input  logic       irq_clear,
  output logic [2:0] mode,
  output logic       in_proc_en,
  output logic       mux_out_en,
  output logic       eos_req,
  output logic       save_state,
  output logic       cfg_defaults,
  output logic       cfg_reload,
  output logic       busy,
  output logic       clk_run,
  output logic       cfg_wr_ok,
  output logic       cfg_wr_err,
  output logic       irq_n
);
  ctl_state_e st_q, st_nxt;
  logic drain_pause_q, drain_pause_nxt;

  // Named internal events
  logic acc;        // command accepted this cycle
  logic drain_fin;  // both boundaries reached during the wait
  logic tmr_zero;   // reload timer exhausted
  logic done_evt;   // a transition completes at this edge
  logic def_evt;    // defaults are restored at this edge
  logic rl_start;   // reload begins at this edge
  logic eos_set, sav_set;

  mc_cmd_filter u_filter (
    .st(st_q), .vld(cmd_valid), .code(cmd_code), .acc(acc)
  );

  mc_boundary_track #(.N_SRC(2)) u_track (
    .clk(clk), .rst_n(rst_n), .active(st_q == S_DRAIN),
    .evt({afr_end, gop_end}), .fin(drain_fin)
  );

  mc_reload_timer #(.RELOAD_CYCLES(RELOAD_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(rl_start),
    .active(st_q == S_RELOAD), .zero(tmr_zero)
  );

  mc_irq_unit u_irq (
    .clk(clk), .rst_n(rst_n), .set(done_evt), .clr(irq_clear),
    .mask(irq_mask), .irq_n(irq_n)
  );

  always_comb begin
    st_nxt          = st_q;
    drain_pause_nxt = drain_pause_q;
    done_evt        = 1'b0;
    def_evt         = 1'b0;
    rl_start        = 1'b0;
    case (st_q)
      S_IDLE: if (acc) begin
        if (cmd_code == CMD_ENABLE)     begin st_nxt = S_STOP; done_evt = 1'b1; end
        else if (cmd_code == CMD_START)       st_nxt = S_PASS;
        else if (cmd_code == CMD_SLEEP) begin st_nxt = S_OFF;  done_evt = 1'b1; end
      end
      S_STOP, S_PAUSED: if (acc) begin
        if (cmd_code == CMD_START)       begin st_nxt = S_ENC;  done_evt = 1'b1; end
        else if (cmd_code == CMD_RECONF) begin st_nxt = S_IDLE; done_evt = 1'b1; end
      end
      S_ENC: if (acc) begin
        if (cmd_code == CMD_HALT)       begin st_nxt = S_DRAIN; drain_pause_nxt = 1'b0; end
        else if (cmd_code == CMD_PAUSE) begin st_nxt = S_DRAIN; drain_pause_nxt = 1'b1; end
      end
      S_PASS: begin st_nxt = S_ENC; done_evt = 1'b1; end
      S_DRAIN: if (drain_fin) begin
        st_nxt   = drain_pause_q ? S_PAUSED : S_STOP;
        done_evt = 1'b1;
      end
      S_RELOAD: if (tmr_zero) begin st_nxt = S_IDLE; done_evt = 1'b1; end
      default: ;
    endcase
    // Commands that override any state that accepts them
    if (acc && cmd_code == CMD_SRST) begin
      st_nxt = S_IDLE; def_evt = 1'b1; done_evt = 1'b1;
    end else if (acc && cmd_code == CMD_FORCE) begin
      st_nxt = S_RELOAD; def_evt = 1'b1; rl_start = 1'b1; done_evt = 1'b0;
    end
  end

  assign eos_set = (st_q == S_DRAIN) && (st_nxt == S_STOP);
  assign sav_set = (st_q == S_DRAIN) && (st_nxt == S_PAUSED);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q          <= S_IDLE;
      drain_pause_q <= 1'b0;
      eos_req       <= 1'b0;
      save_state    <= 1'b0;
      cfg_defaults  <= 1'b0;
    end else begin
      st_q          <= st_nxt;
      drain_pause_q <= drain_pause_nxt;
      eos_req       <= eos_set;
      save_state    <= sav_set;
      cfg_defaults  <= def_evt;
    end
  end

  assign mode       = mode_of(st_q);
  assign in_proc_en = st_q inside {S_STOP, S_ENC, S_PAUSED, S_PASS, S_DRAIN};
  assign mux_out_en = st_q inside {S_ENC, S_DRAIN};
  assign busy       = st_q inside {S_PASS, S_DRAIN, S_RELOAD};
  assign cfg_reload = (st_q == S_RELOAD);
  assign clk_run    = (st_q != S_OFF);
  assign cfg_wr_ok  = cfg_wr &&  cfg_allow(st_q, cfg_dyn);
  assign cfg_wr_err = cfg_wr && !cfg_allow(st_q, cfg_dyn);

  a_r2_mux_needs_input: assert property (@(posedge clk) disable iff (!rst_n)
    mux_out_en |-> in_proc_en);
  a_r3_start_via_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_ENCODE) |-> ($past(mode) != MODE_IDLE));
  a_r4_eos_after_encode: assert property (@(posedge clk) disable iff (!rst_n)
    eos_req |-> (mode == MODE_STOP && $past(mode) == MODE_ENCODE));
  a_r5_save_alone: assert property (@(posedge clk) disable iff (!rst_n)
    save_state |-> (mode == MODE_PAUSED && !eos_req && $past(mode) == MODE_ENCODE));
  a_r8_sleep_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_OFF) |=> (mode == MODE_OFF && !clk_run));
  a_r10_reload_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_reload |-> (!mux_out_en && !in_proc_en && busy));
  a_r11_wr_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_wr_ok && cfg_wr_err));
endmodule

// File: tb/tb_mode_ctl_top.sv
module tb_mode_ctl_top;
  localparam int CLK_PERIOD = 10;
  localparam int RC = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 0, gop_end = 0, afr_end = 0;
  logic [3:0] cmd_code = '0;
  logic cfg_wr = 0, cfg_dyn = 0, irq_mask = 0, irq_clear = 0;
  logic [2:0] mode;
  logic in_proc_en, mux_out_en, eos_req, save_state, cfg_defaults;
  logic cfg_reload, busy, clk_run, cfg_wr_ok, cfg_wr_err, irq_n;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mode_ctl_top #(.RELOAD_CYCLES(RC)) dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .gop_end(gop_end), .afr_end(afr_end), .cfg_wr(cfg_wr), .cfg_dyn(cfg_dyn),
    .irq_mask(irq_mask), .irq_clear(irq_clear), .mode(mode),
    .in_proc_en(in_proc_en), .mux_out_en(mux_out_en), .eos_req(eos_req),
    .save_state(save_state), .cfg_defaults(cfg_defaults), .cfg_reload(cfg_reload),
    .busy(busy), .clk_run(clk_run), .cfg_wr_ok(cfg_wr_ok), .cfg_wr_err(cfg_wr_err),
    .irq_n(irq_n)
  );

  // Vector: cmd[11:8] gop[7] afr[6] | expected mode[5:3] busy[2] in[1] mux[0]
  localparam int NV = 19;
  localparam logic [11:0] VEC [NV] = '{
    {4'd0, 1'b0, 1'b0, 3'd0, 1'b0, 1'b0, 1'b0},
    {4'd3, 1'b0, 1'b0, 3'd1, 1'b0, 1'b1, 1'b0},
    {4'd0, 1'b0, 1'b0, 3'd1, 1'b0, 1'b1, 1'b0},
    {4'd4, 1'b0, 1'b0, 3'd2, 1'b0, 1'b1, 1'b1},
    {4'd6, 1'b0, 1'b0, 3'd2, 1'b1, 1'b1, 1'b1},
    {4'd0, 1'b1, 1'b0, 3'd2, 1'b1, 1'b1, 1'b1},
    {4'd0, 1'b0, 1'b1, 3'd3, 1'b0, 1'b1, 1'b0},
    {4'd4, 1'b0, 1'b0, 3'd2, 1'b0, 1'b1, 1'b1},
    {4'd5, 1'b1, 1'b1, 3'd2, 1'b1, 1'b1, 1'b1},
    {4'd0, 1'b1, 1'b1, 3'd1, 1'b0, 1'b1, 1'b0},
    {4'd2, 1'b0, 1'b0, 3'd0, 1'b0, 1'b0, 1'b0},
    {4'd4, 1'b0, 1'b0, 3'd1, 1'b1, 1'b1, 1'b0},
    {4'd0, 1'b0, 1'b0, 3'd2, 1'b0, 1'b1, 1'b1},
    {4'd3, 1'b0, 1'b0, 3'd2, 1'b0, 1'b1, 1'b1},
    {4'd7, 1'b0, 1'b0, 3'd2, 1'b0, 1'b1, 1'b1},
    {4'd5, 1'b0, 1'b0, 3'd2, 1'b1, 1'b1, 1'b1},
    {4'd4, 1'b0, 1'b0, 3'd2, 1'b1, 1'b1, 1'b1},
    {4'd0, 1'b0, 1'b1, 3'd2, 1'b1, 1'b1, 1'b1},
    {4'd0, 1'b1, 1'b0, 3'd1, 1'b0, 1'b1, 1'b0}
  };

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Called at a falling edge; drives one cycle and returns at the next falling edge.
  task automatic step(input logic [3:0] c, input logic g, input logic a, input logic cl);
    cmd_valid = (c != 4'd0);
    cmd_code  = c;
    gop_end   = g;
    afr_end   = a;
    irq_clear = cl;
    @(negedge clk);
    cmd_valid = 0; cmd_code = '0; gop_end = 0; afr_end = 0; irq_clear = 0;
  endtask

  task automatic wr_probe(input string tag, input logic dyn, input logic exp_ok);
    cfg_wr = 1; cfg_dyn = dyn;
    #1;
    chk({tag, " ok"}, cfg_wr_ok, exp_ok);
    chk({tag, " err"}, cfg_wr_err, !exp_ok);
    cfg_wr = 0; cfg_dyn = 0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int n;
    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1 mode in reset", mode, 0);
    chk("R1 clk_run in reset", clk_run, 1);
    rst_n = 1;
    @(negedge clk);
    chk("R1 mode", mode, 0);
    chk("R1 enables", {in_proc_en, mux_out_en}, 0);
    chk("R1 busy", busy, 0);
    chk("R1 irq_n", irq_n, 1);
    chk("R1 strobes", {eos_req, save_state, cfg_defaults, cfg_reload}, 0);

    // R2 R3 R4 R5 R7 R9: table walk
    irq_mask = 1;
    for (int i = 0; i < NV; i++) begin
      step(VEC[i][11:8], VEC[i][7], VEC[i][6], 1'b0);
      chk($sformatf("R2/R3/R4/R5/R9 vec %0d mode", i), mode, VEC[i][5:3]);
      chk($sformatf("R3/R4/R9 vec %0d busy", i), busy, VEC[i][2]);
      chk($sformatf("R2/R5 vec %0d in_proc", i), in_proc_en, VEC[i][1]);
      chk($sformatf("R2/R3 vec %0d mux", i), mux_out_en, VEC[i][0]);
    end

    // R4: end marker strobe on the first Stop cycle only
    step(4'd4, 0, 0, 0);
    step(4'd5, 0, 0, 0);
    chk("R4 no eos while waiting", eos_req, 0);
    step(4'd0, 1, 1, 0);
    chk("R4 stop mode", mode, 1);
    chk("R4 eos pulse", eos_req, 1);
    chk("R4 no save on stop", save_state, 0);
    step(4'd0, 0, 0, 0);
    chk("R4 eos one cycle", eos_req, 0);

    // R5: pause saves state and has no marker
    step(4'd4, 0, 0, 0);
    step(4'd6, 0, 0, 0);
    step(4'd0, 0, 1, 0);
    chk("R5 still waiting", busy, 1);
    step(4'd0, 1, 0, 0);
    chk("R5 paused mode", mode, 3);
    chk("R5 save pulse", save_state, 1);
    chk("R5 no eos", eos_req, 0);
    step(4'd0, 0, 0, 0);
    chk("R5 save one cycle", save_state, 0);

    // R13: undefined codes ignored
    step(4'd9, 0, 0, 0);
    chk("R13 code 9 ignored", mode, 3);
    step(4'd15, 0, 0, 0);
    chk("R13 code 15 ignored", mode, 3);
    step(4'd4, 0, 0, 0);
    chk("R5 resume to encode", mode, 2);

    // R6: soft reset cuts a deferred wait
    step(4'd5, 0, 0, 0);
    chk("R6 waiting", busy, 1);
    step(4'd1, 1, 0, 0);
    chk("R6 idle", mode, 0);
    chk("R6 not busy", busy, 0);
    chk("R6 defaults pulse", cfg_defaults, 1);
    step(4'd0, 0, 0, 0);
    chk("R6 defaults one cycle", cfg_defaults, 0);

    // R7: reconfigure keeps configuration
    step(4'd3, 0, 0, 0);
    step(4'd2, 0, 0, 0);
    chk("R7 idle", mode, 0);
    chk("R7 no defaults", cfg_defaults, 0);

    // R10: forced reconfigure from a deferred wait
    step(4'd3, 0, 0, 0);
    step(4'd4, 0, 0, 0);
    step(4'd5, 0, 0, 0);
    step(4'd8, 0, 0, 0);
    chk("R10 defaults pulse", cfg_defaults, 1);
    chk("R10 reload", cfg_reload, 1);
    chk("R10 busy", busy, 1);
    chk("R10 enables low", {in_proc_en, mux_out_en}, 0);
    wr_probe("R11 reload dynamic", 1'b1, 1'b0);
    n = 1;
    step(4'd3, 0, 0, 0);   // R9: dropped during reload
    if (cfg_reload) n++;
    chk("R9 enable dropped in reload", mode, 0);
    for (int k = 0; k < 50 && cfg_reload; k++) begin
      step(4'd0, 0, 0, 0);
      if (cfg_reload) n++;
    end
    chk("R10 reload length", n, RC);
    chk("R10 ends idle", mode, 0);
    chk("R10 busy cleared", busy, 0);

    // R11: write filter
    wr_probe("R11 idle static", 1'b0, 1'b1);
    step(4'd3, 0, 0, 0);
    wr_probe("R11 stop static", 1'b0, 1'b0);
    wr_probe("R11 stop dynamic", 1'b1, 1'b1);

    // R12: interrupt
    irq_mask = 0;
    step(4'd0, 0, 0, 1);
    chk("R12 cleared", irq_n, 1);
    step(4'd4, 0, 0, 0);
    chk("R12 raised on start", irq_n, 0);
    irq_mask = 1; #1;
    chk("R12 masked", irq_n, 1);
    irq_mask = 0; #1;
    chk("R12 unmasked", irq_n, 0);
    step(4'd0, 0, 0, 1);
    chk("R12 clear", irq_n, 1);
    step(4'd5, 0, 0, 0);
    chk("R12 no irq on deferred accept", irq_n, 1);
    step(4'd0, 1, 1, 1);
    chk("R12 completion beats clear", irq_n, 0);

    // R8: power-down
    step(4'd2, 0, 0, 1);
    step(4'd7, 0, 0, 0);
    chk("R8 off mode", mode, 4);
    chk("R8 clock stopped", clk_run, 0);
    wr_probe("R11 off dynamic", 1'b1, 1'b0);
    step(4'd1, 0, 0, 0);
    step(4'd8, 0, 0, 0);
    step(4'd4, 0, 0, 0);
    chk("R8 commands ignored", mode, 4);
    chk("R8 no defaults", cfg_defaults, 0);
    rst_n = 0;
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R8 hard reset leaves", mode, 0);
    chk("R8 clock runs", clk_run, 1);

    finish_run();
  end
endmodule